// File: doc/BRIEF.md
# Front Panel Secure Lockout Controller

This block sits between the debounced front panel push-buttons and the system actions they start. The buttons are power, reset, sleep, NMI and chassis identify. Each press is edge-detected. The press then becomes a one-cycle action pulse unless something blocks it. Three things can block a press: a secure-mode state, a set of per-button lock bits held in an options register, or an external lockout line. The lockout line refuses only power-up.

Secure mode is active when the force bit is set. It is also active when the enable bit is set and the keyboard controller's secure request line is high. Secure mode guards only the power, reset and sleep buttons. The NMI and identify buttons always stay usable under secure mode, so a hung machine can still be recovered. A press that secure mode blocks raises a one-cycle violation pulse with a 3-bit code that names the button. A press that only a lock bit or the lockout line blocks is dropped silently. The whole options state clears on AC power application, system power-on, system reset and controller reset.

Top module: `fp_secure_lockout`

## Requirements
- R1: During and right after controller reset (`rst`), `act_o` is 0, `viol_o` is 0, `viol_code_o` is 0 and all option bits are 0.
- R2: A rising edge on `btn_i[k]` that nothing blocks gives `act_o[k]=1` for exactly one cycle, one clock after the edge is sampled. A held button gives only one pulse. Button indices are power=0, reset=1, sleep=2, NMI=3, identify=4.
- R3: While secure mode is active, presses of power, reset and sleep give no action pulse.
- R4: While secure mode is active, NMI and identify presses still give their action pulses, unless a lock bit blocks them.
- R5: A press of power, reset or sleep while secure mode is active gives one `viol_o` pulse, with `viol_code_o` equal to the button index. A held press gives no further pulses.
- R6: Secure mode is active exactly when force (options bit 1) is set, or when enable (options bit 0) is set and `kbd_secure_i` is high. With enable clear, `kbd_secure_i` has no effect.
- R7: Lock bits (options bits 6:2, bit 2+k for button k) block button k whether or not secure mode is active. This includes NMI. A press blocked only by a lock bit raises no violation.
- R8: When `sys_on_i` is low and `panel_lock_i` is high, a power press gives no action and no violation. With `sys_on_i` high, or for any other button, `panel_lock_i` has no effect.
- R9: A pulse on `clr_ac_i`, `clr_pwr_on_i` or `clr_sys_rst_i` clears every option bit. Clearing takes priority over a write in the same cycle.
- R10: When several guarded buttons are blocked by secure mode in the same cycle, one violation is reported, with the lowest button index.
- R11: A write (`opt_we_i`, `opt_wdata_i`) takes effect at the clock edge that samples it. A press sampled at that same edge is gated by the old options.
- R12: The same button never gets an action pulse and a violation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| clr_ac_i | input | 1 | AC power applied; clears options |
| clr_pwr_on_i | input | 1 | System power-on; clears options |
| clr_sys_rst_i | input | 1 | System reset; clears options |
| btn_i | input | 5 | Debounced active-high button levels |
| kbd_secure_i | input | 1 | Secure request from keyboard controller |
| panel_lock_i | input | 1 | External front panel lockout |
| sys_on_i | input | 1 | High while the system is powered |
| opt_we_i | input | 1 | Options write enable |
| opt_wdata_i | input | 7 | Options write data: bit0 enable, bit1 force, bits6:2 locks |
| act_o | output | 5 | One-cycle action pulses per button |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Index of the blocked button |

## Verification
On every cycle, the assertions check several properties. Action pulses need a high button level in the previous cycle. Guarded actions never appear while secure mode was active. A locked button never acts. A violation always carries a guarded code and never comes together with that button's action. Scenarios in the bench have to show the rest. These are the secure-mode derivation from enable and the keyboard line, the lockout only refusing power-up, the lowest-index choice, the write-versus-press timing, and each clear source.

// File: rtl/fp_lock_pkg.sv
package fp_lock_pkg;

    localparam int NUM_BTN  = 5;
    localparam int CODE_W   = 3;
    localparam int OPT_W    = 2 + NUM_BTN;

    typedef enum logic [CODE_W-1:0] {
        BTN_POWER = 3'd0,
        BTN_RESET = 3'd1,
        BTN_SLEEP = 3'd2,
        BTN_NMI   = 3'd3,
        BTN_IDENT = 3'd4
    } btn_idx_e;

    localparam logic [NUM_BTN-1:0] GUARD_MASK = 5'b00111;
    localparam logic [NUM_BTN-1:0] POWER_MASK = 5'b00001;

    typedef struct packed {
        logic [NUM_BTN-1:0] lock;
        logic               force_on;
        logic               enable;
    } opts_t;

    typedef struct packed {
        logic [NUM_BTN-1:0] go;
        logic               viol;
        logic [CODE_W-1:0]  code;
    } gate_res_t;

    function automatic logic [CODE_W-1:0] lowest_set(input logic [NUM_BTN-1:0] v);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = NUM_BTN - 1; i >= 0; i--) begin
            if (v[i]) r = CODE_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/fp_edge_detect.sv
module fp_edge_detect #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b0;
            else     prev_q[g] <= lvl_i[g];
        end
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/fp_option_reg.sv
module fp_option_reg
    import fp_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [OPT_W-1:0] wdata_i,
    output opts_t            opts_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)  opts_o <= '0;
        else if (we_i)     opts_o <= opts_t'(wdata_i);
    end
endmodule

// File: rtl/fp_gate_logic.sv
module fp_gate_logic
    import fp_lock_pkg::*;
(
    input  opts_t              opts_i,
    input  logic               kbd_secure_i,
    input  logic               panel_lock_i,
    input  logic               sys_on_i,
    input  logic [NUM_BTN-1:0] press_i,
    output logic               secure_o,
    output gate_res_t          res_o
);
    logic [NUM_BTN-1:0] blocked;
    logic [NUM_BTN-1:0] viol_req;

    always_comb begin
        secure_o = opts_i.force_on | (opts_i.enable & kbd_secure_i);
        blocked  = opts_i.lock;
        if (secure_o)                  blocked = blocked | GUARD_MASK;
        if (panel_lock_i && !sys_on_i) blocked = blocked | POWER_MASK;
        viol_req   = secure_o ? (press_i & GUARD_MASK) : '0;
        res_o.go   = press_i & ~blocked;
        res_o.viol = |viol_req;
        res_o.code = lowest_set(viol_req);
    end
endmodule

// File: rtl/fp_secure_lockout.sv
module fp_secure_lockout
    import fp_lock_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_ac_i,
    input  logic         clr_pwr_on_i,
    input  logic         clr_sys_rst_i,
    input  logic [4:0]   btn_i,
    input  logic         kbd_secure_i,
    input  logic         panel_lock_i,
    input  logic         sys_on_i,
    input  logic         opt_we_i,
    input  logic [6:0]   opt_wdata_i,
    output logic [4:0]   act_o,
    output logic         viol_o,
    output logic [2:0]   viol_code_o
);
    logic [NUM_BTN-1:0] press;
    opts_t              opts;
    logic               secure;
    gate_res_t          res;

    fp_edge_detect #(.W(NUM_BTN)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (btn_i),
        .rise_o (press)
    );

    fp_option_reg u_opts (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr_ac_i | clr_pwr_on_i | clr_sys_rst_i),
        .we_i    (opt_we_i),
        .wdata_i (opt_wdata_i),
        .opts_o  (opts)
    );

    fp_gate_logic u_gate (
        .opts_i       (opts),
        .kbd_secure_i (kbd_secure_i),
        .panel_lock_i (panel_lock_i),
        .sys_on_i     (sys_on_i),
        .press_i      (press),
        .secure_o     (secure),
        .res_o        (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_o       <= '0;
            viol_o      <= 1'b0;
            viol_code_o <= '0;
        end else begin
            act_o       <= res.go;
            viol_o      <= res.viol;
            viol_code_o <= res.viol ? res.code : '0;
        end
    end
endmodule

// File: rtl/fp_secure_lockout_chk.sv
module fp_secure_lockout_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] btn_i,
    input logic [4:0] act_o,
    input logic       viol_o,
    input logic [2:0] viol_code_o,
    input logic       secure,
    input logic [4:0] lock
);
    a_r2_act_needs_level: assert property (@(posedge clk) disable iff (rst)
        (act_o & ~$past(btn_i)) == 5'b0);

    a_r3_guarded_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(secure) |-> (act_o[2:0] == 3'b0));

    a_r7_locked_quiet: assert property (@(posedge clk) disable iff (rst)
        (act_o & $past(lock)) == 5'b0);

    a_r5_code_guarded: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (viol_code_o <= 3'd2));

    a_r5_viol_needs_secure: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> $past(secure));

    a_r12_no_double: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (act_o[viol_code_o] == 1'b0));

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (act_o == 5'b0 && !viol_o));
endmodule

bind fp_secure_lockout fp_secure_lockout_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .btn_i       (btn_i),
    .act_o       (act_o),
    .viol_o      (viol_o),
    .viol_code_o (viol_code_o),
    .secure      (secure),
    .lock        (opts.lock)
);

// File: tb/test_fp_secure_lockout.sv
module test_fp_secure_lockout;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_ac = 0, clr_pwr_on = 0, clr_sys_rst = 0;
    logic [4:0] btn = '0;
    logic       kbd = 0, plock = 0, son = 1;
    logic       we = 0;
    logic [6:0] wdata = '0;
    logic [4:0] act;
    logic       viol;
    logic [2:0] code;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fp_secure_lockout i_fp_secure_lockout (
        .clk(clk), .rst(rst), .clr_ac_i(clr_ac), .clr_pwr_on_i(clr_pwr_on),
        .clr_sys_rst_i(clr_sys_rst), .btn_i(btn), .kbd_secure_i(kbd),
        .panel_lock_i(plock), .sys_on_i(son), .opt_we_i(we), .opt_wdata_i(wdata),
        .act_o(act), .viol_o(viol), .viol_code_o(code)
    );

    // vector: opts(7) kbd lockout sys_on btn(5) exp_act(5) exp_viol exp_code(3)
    localparam int NV = 15;
    localparam logic [23:0] VEC [NV] = '{
        {7'h00, 1'b0, 1'b0, 1'b1, 5'b00001, 5'b00001, 1'b0, 3'd0}, // R2
        {7'h00, 1'b0, 1'b0, 1'b1, 5'b11111, 5'b11111, 1'b0, 3'd0}, // R2
        {7'h02, 1'b0, 1'b0, 1'b1, 5'b00001, 5'b00000, 1'b1, 3'd0}, // R3 R5
        {7'h02, 1'b0, 1'b0, 1'b1, 5'b11000, 5'b11000, 1'b0, 3'd0}, // R4
        {7'h02, 1'b0, 1'b0, 1'b1, 5'b00110, 5'b00000, 1'b1, 3'd1}, // R10
        {7'h01, 1'b1, 1'b0, 1'b1, 5'b00100, 5'b00000, 1'b1, 3'd2}, // R6
        {7'h00, 1'b1, 1'b0, 1'b1, 5'b00010, 5'b00010, 1'b0, 3'd0}, // R6
        {7'h01, 1'b0, 1'b0, 1'b1, 5'b00010, 5'b00010, 1'b0, 3'd0}, // R6
        {7'h20, 1'b0, 1'b0, 1'b1, 5'b01000, 5'b00000, 1'b0, 3'd0}, // R7
        {7'h04, 1'b0, 1'b0, 1'b1, 5'b00001, 5'b00000, 1'b0, 3'd0}, // R7
        {7'h06, 1'b0, 1'b0, 1'b1, 5'b00001, 5'b00000, 1'b1, 3'd0}, // R7 R5
        {7'h00, 1'b0, 1'b1, 1'b0, 5'b00001, 5'b00000, 1'b0, 3'd0}, // R8
        {7'h00, 1'b0, 1'b1, 1'b1, 5'b00001, 5'b00001, 1'b0, 3'd0}, // R8
        {7'h00, 1'b0, 1'b1, 1'b0, 5'b00010, 5'b00010, 1'b0, 3'd0}, // R8
        {7'h22, 1'b0, 1'b0, 1'b1, 5'b01000, 5'b00000, 1'b0, 3'd0}  // R7 R4
    };

    task automatic chk(input string req, input int actual, input int expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic out_chk(input string req, input logic [4:0] ea,
                           input logic ev, input logic [2:0] ec);
        chk({req, " act"}, int'(act), int'(ea));
        chk({req, " viol"}, int'(viol), int'(ev));
        if (ev) chk({req, " code"}, int'(code), int'(ec));
    endtask

    task automatic wr(input logic [6:0] d);
        @(negedge clk); we = 1; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic press(input logic [4:0] b);
        btn = b;
        @(negedge clk);
        btn = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        out_chk("R1 in reset", 5'b0, 1'b0, 3'd0);
        chk("R1 code in reset", int'(code), 0);
        rst = 0;
        @(negedge clk);
        out_chk("R1 after reset", 5'b0, 1'b0, 3'd0);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            e = VEC[v];
            wr(e[23:17]);
            kbd = e[16]; plock = e[15]; son = e[14];
            btn = e[13:9];
            @(negedge clk);
            out_chk($sformatf("vector %0d", v), e[8:4], e[3], e[2:0]);
            btn = '0; kbd = 0; plock = 0; son = 1;
            @(negedge clk);
            out_chk($sformatf("vector %0d idle", v), 5'b0, 1'b0, 3'd0);
        end

        // R2: held button gives one pulse only
        wr(7'h00);
        btn = 5'b10000;
        @(negedge clk); chk("R2 held first", int'(act), 5'b10000);
        @(negedge clk); chk("R2 held second", int'(act), 0);
        @(negedge clk); chk("R2 held third", int'(act), 0);
        btn = '0; @(negedge clk);

        // R5: held blocked press gives one violation only
        wr(7'h02);
        btn = 5'b00010;
        @(negedge clk); chk("R5 held viol first", int'(viol), 1);
        chk("R5 held code", int'(code), 1);
        @(negedge clk); chk("R5 held viol second", int'(viol), 0);
        btn = '0; @(negedge clk);

        // R9: each clear source drops force-on
        for (int s = 0; s < 4; s++) begin
            wr(7'h02);
            if (s == 0) clr_ac = 1;
            if (s == 1) clr_pwr_on = 1;
            if (s == 2) clr_sys_rst = 1;
            if (s == 3) begin clr_ac = 1; we = 1; wdata = 7'h02; end // clear beats write
            @(negedge clk);
            clr_ac = 0; clr_pwr_on = 0; clr_sys_rst = 0; we = 0;
            press(5'b00001);
            chk($sformatf("R9 clear src %0d act", s), int'(act), 1);
            chk($sformatf("R9 clear src %0d viol", s), int'(viol), 0);
            @(negedge clk);
        end

        // R1: controller reset clears options
        wr(7'h02);
        rst = 1; @(negedge clk); rst = 0; @(negedge clk);
        press(5'b00001);
        chk("R1 reset clears opts", int'(act), 1);
        @(negedge clk);

        // R11: write and press at the same edge use old options
        wr(7'h00);
        we = 1; wdata = 7'h02; btn = 5'b00001;
        @(negedge clk);
        we = 0; btn = '0;
        chk("R11 same-edge press old opts", int'(act), 1);
        @(negedge clk);
        press(5'b00001);
        chk("R11 next press blocked", int'(act), 0);
        chk("R11 next press viol", int'(viol), 1);
        @(negedge clk);

        // R6: enable with keyboard line toggling mid-stream
        wr(7'h01);
        kbd = 1; press(5'b00001);
        chk("R6 kbd high blocks", int'(act), 0);
        kbd = 0; @(negedge clk);
        press(5'b00001);
        chk("R6 kbd low passes", int'(act), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule